// File: doc/BRIEF.md
# Address-Range Access Watchpoint Unit

This block sits next to a memory arbiter and looks at each access the arbiter grants. Four watchpoint slots each hold an inclusive address window, a mask of operation kinds and a mask of requesting clients. When a granted access falls inside a slot's window, has an enabled operation kind and comes from an enabled client, the slot records what happened and raises its pending bit. The recorded data is the client as a one-hot set, the client index, the address, the operation and the access size. A mask decides which pending bits reach the single interrupt line.

Software sets up the slots and reads the results through a simple word-addressed register port. Writes are synchronous and reads are combinational. Each slot has two acknowledges with separate roles. A per-slot acknowledge re-arms the slot's capture registers. A global write-one-to-clear acknowledge clears pending interrupt bits. Software normally reads the captured fields, writes the per-slot acknowledge and then clears the pending bit.

Top module: `acc_watch_unit`

## Requirements
- R1: After reset every configuration register, capture register, the interrupt mask and all pending bits read as zero, and `irq` is low.
- R2: Slot i hits on a granted access only when first <= address <= last (inclusive at both ends), the operation bit is set in its operation mask (bit 0 = read, bit 1 = write), and the bit for the access's client index is set in its client mask. A slot whose first address is above its last address never hits.
- R3: When a slot hits while not holding a capture, its capture registers take the access's one-hot client set, address, operation (2'b01 read, 2'b10 write), client index and size. These values are readable at the clock edge after the access.
- R4: While a slot holds a capture, further hits on that slot leave all its capture registers unchanged.
- R5: A write of any value to a slot's acknowledge register releases the held capture, so the next hit captures again. This write does not clear that slot's pending bit.
- R6: Every hit sets the slot's pending bit. A write to the global acknowledge register clears each pending bit whose data bit i is 1. A hit in the same cycle as the clear leaves the bit set.
- R7: The masked status register reads pending AND mask (bit i = slot i). `irq` is high exactly when masked status is non-zero. The raw pending bits stay readable whatever the mask holds.
- R8: Register map (word address): slot i occupies 16*i + offset, with offset 0 first, 1 last, 2 operation mask, 3 client mask, 4 captured client set, 5 captured address, 6 captured operation, 7 captured client index, 8 captured size, 9 acknowledge. The global registers are 64 interrupt mask, 65 masked status, 66 global acknowledge and 67 raw pending. Configuration registers read back what was written. Unmapped addresses read as zero.
- R9: An access presented with `acc_vld` low never causes a hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_vld | input | 1 | A granted access is present this cycle |
| acc_addr | input | ADDR_W | Address of the granted access |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_cli | input | CLI_IW | Index of the client that owns the access |
| acc_size | input | SIZE_W | Size of the access |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 7 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the unit with a 12-bit address, four clients and a 3-bit size. At that size every address from 0 to 47 can be swept with both operations and all four clients against all four slots. The sweep crosses each window edge, covers a single-address window and covers a reversed window that must stay silent. Directed sequences then cover capture freezing, the difference between the two acknowledges, set-over-clear collisions, masking and an idle strobe.

// File: rtl/awu_pkg.sv
package awu_pkg;
  localparam int NUM_WP  = 4;
  localparam int DATA_W  = 32;
  localparam int REG_AW  = 7;
  localparam int OFS_W   = 4;
  localparam int SLOT_IW = $clog2(NUM_WP);

  localparam logic [OFS_W-1:0] OFS_FIRST = 4'd0;
  localparam logic [OFS_W-1:0] OFS_LAST  = 4'd1;
  localparam logic [OFS_W-1:0] OFS_OPM   = 4'd2;
  localparam logic [OFS_W-1:0] OFS_CLIM  = 4'd3;
  localparam logic [OFS_W-1:0] OFS_CCLI  = 4'd4;
  localparam logic [OFS_W-1:0] OFS_CADDR = 4'd5;
  localparam logic [OFS_W-1:0] OFS_COP   = 4'd6;
  localparam logic [OFS_W-1:0] OFS_CIDX  = 4'd7;
  localparam logic [OFS_W-1:0] OFS_CSIZE = 4'd8;
  localparam logic [OFS_W-1:0] OFS_ACK   = 4'd9;

  localparam logic [5:0] GLB_MASK = 6'd0;
  localparam logic [5:0] GLB_STAT = 6'd1;
  localparam logic [5:0] GLB_GACK = 6'd2;
  localparam logic [5:0] GLB_PEND = 6'd3;

  // inclusive window test on zero-extended values
  function automatic logic in_window(input logic [DATA_W-1:0] lo,
                                     input logic [DATA_W-1:0] hi,
                                     input logic [DATA_W-1:0] a);
    return (a >= lo) && (a <= hi);
  endfunction

  // operation kind as a one-hot code: 01 read, 10 write
  function automatic logic [1:0] op_code(input logic wr);
    return wr ? 2'b10 : 2'b01;
  endfunction
endpackage

// File: rtl/awu_slot.sv
module awu_slot
  import awu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int N_CLI  = 16,
  parameter int SIZE_W = 4,
  localparam int CLI_IW = $clog2(N_CLI)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_vld,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_wr,
  input  logic [CLI_IW-1:0] acc_cli,
  input  logic [SIZE_W-1:0] acc_size,
  input  logic              wr_en,
  input  logic [OFS_W-1:0]  wr_ofs,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ack,
  input  logic [OFS_W-1:0]  rd_ofs,
  output logic [DATA_W-1:0] rd_data,
  output logic              hit,
  output logic              held,
  output logic [ADDR_W-1:0] cap_addr
);
  logic [ADDR_W-1:0] first_q, last_q, cap_addr_q;
  logic [1:0]        opm_q, cap_op_q;
  logic [N_CLI-1:0]  clim_q, cap_cli_q, cli_onehot;
  logic [CLI_IW-1:0] cap_idx_q;
  logic [SIZE_W-1:0] cap_size_q;
  logic              held_q;
  logic              range_ok, op_ok, cli_ok;

  assign cli_onehot = N_CLI'(1) << acc_cli;
  assign range_ok   = in_window(DATA_W'(first_q), DATA_W'(last_q), DATA_W'(acc_addr));
  assign op_ok      = |(opm_q & op_code(acc_wr));
  assign cli_ok     = |(clim_q & cli_onehot);
  assign hit        = acc_vld & range_ok & op_ok & cli_ok;
  assign held       = held_q;
  assign cap_addr   = cap_addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      first_q    <= '0;
      last_q     <= '0;
      opm_q      <= '0;
      clim_q     <= '0;
      cap_cli_q  <= '0;
      cap_addr_q <= '0;
      cap_op_q   <= '0;
      cap_idx_q  <= '0;
      cap_size_q <= '0;
      held_q     <= 1'b0;
    end else begin
      if (wr_en) begin
        case (wr_ofs)
          OFS_FIRST: first_q <= wr_data[ADDR_W-1:0];
          OFS_LAST:  last_q  <= wr_data[ADDR_W-1:0];
          OFS_OPM:   opm_q   <= wr_data[1:0];
          OFS_CLIM:  clim_q  <= wr_data[N_CLI-1:0];
          default: ;
        endcase
      end
      held_q <= hit | (held_q & ~ack);
      if (hit && !held_q) begin
        cap_cli_q  <= cli_onehot;
        cap_addr_q <= acc_addr;
        cap_op_q   <= op_code(acc_wr);
        cap_idx_q  <= acc_cli;
        cap_size_q <= acc_size;
      end
    end
  end

  always_comb begin
    case (rd_ofs)
      OFS_FIRST: rd_data = DATA_W'(first_q);
      OFS_LAST:  rd_data = DATA_W'(last_q);
      OFS_OPM:   rd_data = DATA_W'(opm_q);
      OFS_CLIM:  rd_data = DATA_W'(clim_q);
      OFS_CCLI:  rd_data = DATA_W'(cap_cli_q);
      OFS_CADDR: rd_data = DATA_W'(cap_addr_q);
      OFS_COP:   rd_data = DATA_W'(cap_op_q);
      OFS_CIDX:  rd_data = DATA_W'(cap_idx_q);
      OFS_CSIZE: rd_data = DATA_W'(cap_size_q);
      default:   rd_data = '0;
    endcase
  end
endmodule

// File: rtl/awu_irq_ctl.sv
module awu_irq_ctl
  import awu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_WP-1:0] hit,
  input  logic              mask_we,
  input  logic              gack_we,
  input  logic [NUM_WP-1:0] wbits,
  output logic [NUM_WP-1:0] mask,
  output logic [NUM_WP-1:0] pend,
  output logic [NUM_WP-1:0] status,
  output logic              irq
);
  logic [NUM_WP-1:0] mask_q, pend_q, clr;

  assign clr    = gack_we ? wbits : '0;
  assign mask   = mask_q;
  assign pend   = pend_q;
  assign status = pend_q & mask_q;
  assign irq    = |status;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
      pend_q <= '0;
    end else begin
      if (mask_we) mask_q <= wbits;
      pend_q <= hit | (pend_q & ~clr);
    end
  end
endmodule

// File: rtl/acc_watch_unit.sv
module acc_watch_unit
  import awu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int N_CLI  = 16,
  parameter int SIZE_W = 4,
  localparam int CLI_IW = $clog2(N_CLI)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_vld,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_wr,
  input  logic [CLI_IW-1:0] acc_cli,
  input  logic [SIZE_W-1:0] acc_size,
  input  logic              reg_we,
  input  logic [6:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq
);
  logic                           glb_sel;
  logic [SLOT_IW-1:0]             slot_sel;
  logic [OFS_W-1:0]               ofs;
  logic [NUM_WP-1:0]              wp_hit, wp_held, wp_ack, wp_we;
  logic [NUM_WP-1:0][DATA_W-1:0]  wp_rd;
  logic [NUM_WP-1:0][ADDR_W-1:0]  wp_cap_addr;
  logic [NUM_WP-1:0]              imask_q, pend_q, mstat;
  logic                           mask_we, gack_we;

  assign glb_sel  = reg_addr[REG_AW-1];
  assign slot_sel = reg_addr[OFS_W +: SLOT_IW];
  assign ofs      = reg_addr[OFS_W-1:0];
  assign mask_we  = reg_we && glb_sel && (reg_addr[5:0] == GLB_MASK);
  assign gack_we  = reg_we && glb_sel && (reg_addr[5:0] == GLB_GACK);

  for (genvar i = 0; i < NUM_WP; i++) begin : g_slot
    assign wp_we[i]  = reg_we && !glb_sel && (slot_sel == SLOT_IW'(i));
    assign wp_ack[i] = wp_we[i] && (ofs == OFS_ACK);

    awu_slot #(.ADDR_W(ADDR_W), .N_CLI(N_CLI), .SIZE_W(SIZE_W)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .acc_vld  (acc_vld),
      .acc_addr (acc_addr),
      .acc_wr   (acc_wr),
      .acc_cli  (acc_cli),
      .acc_size (acc_size),
      .wr_en    (wp_we[i]),
      .wr_ofs   (ofs),
      .wr_data  (reg_wdata),
      .ack      (wp_ack[i]),
      .rd_ofs   (ofs),
      .rd_data  (wp_rd[i]),
      .hit      (wp_hit[i]),
      .held     (wp_held[i]),
      .cap_addr (wp_cap_addr[i])
    );
  end

  awu_irq_ctl u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .hit     (wp_hit),
    .mask_we (mask_we),
    .gack_we (gack_we),
    .wbits   (reg_wdata[NUM_WP-1:0]),
    .mask    (imask_q),
    .pend    (pend_q),
    .status  (mstat),
    .irq     (irq)
  );

  always_comb begin
    if (glb_sel) begin
      case (reg_addr[5:0])
        GLB_MASK: reg_rdata = DATA_W'(imask_q);
        GLB_STAT: reg_rdata = DATA_W'(mstat);
        GLB_PEND: reg_rdata = DATA_W'(pend_q);
        default:  reg_rdata = '0;
      endcase
    end else begin
      reg_rdata = wp_rd[slot_sel];
    end
  end
endmodule

// File: rtl/awu_checker.sv
module awu_checker
  import awu_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          acc_vld,
  input logic [NUM_WP-1:0]             hit,
  input logic [NUM_WP-1:0]             held,
  input logic [NUM_WP-1:0]             ack,
  input logic [NUM_WP-1:0]             pend,
  input logic [NUM_WP-1:0]             mask,
  input logic                          gack_we,
  input logic [NUM_WP-1:0]             gack_bits,
  input logic [NUM_WP-1:0][ADDR_W-1:0] cap_addr,
  input logic                          irq
);
  assert_idle_no_hit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_vld |-> (hit == '0));

  assert_hit_sets_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit) |=> ((pend & $past(hit)) == $past(hit)));

  assert_irq_needs_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (mask != '0));

  assert_no_pending_no_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend == '0) |-> !irq);

  for (genvar i = 0; i < NUM_WP; i++) begin : g_chk
    assert_gack_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (gack_we && gack_bits[i] && !hit[i]) |=> !pend[i]);

    assert_capture_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
      held[i] |=> $stable(cap_addr[i]));

    assert_hit_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
      hit[i] |=> held[i]);

    assert_ack_releases_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ack[i] && !hit[i]) |=> !held[i]);
  end
endmodule

bind acc_watch_unit awu_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .acc_vld   (acc_vld),
  .hit       (wp_hit),
  .held      (wp_held),
  .ack       (wp_ack),
  .pend      (pend_q),
  .mask      (imask_q),
  .gack_we   (gack_we),
  .gack_bits (reg_wdata[3:0]),
  .cap_addr  (wp_cap_addr),
  .irq       (irq)
);

// File: tb/sim_acc_watch_unit.sv
module sim_acc_watch_unit;
  localparam int AW = 12;
  localparam int NC = 4;
  localparam int SW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          acc_vld = 1'b0;
  logic [AW-1:0] acc_addr = '0;
  logic          acc_wr = 1'b0;
  logic [1:0]    acc_cli = '0;
  logic [SW-1:0] acc_size = '0;
  logic          reg_we = 1'b0;
  logic [6:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  int lo [4] = '{10, 15, 30, 40};
  int hi [4] = '{20, 15, 40, 30};
  int opm[4] = '{1, 3, 2, 3};
  int clm[4] = '{3, 15, 8, 15};

  always #5 clk = ~clk;

  acc_watch_unit #(.ADDR_W(AW), .N_CLI(NC), .SIZE_W(SW)) u0 (
    .clk(clk), .rst_n(rst_n), .acc_vld(acc_vld), .acc_addr(acc_addr),
    .acc_wr(acc_wr), .acc_cli(acc_cli), .acc_size(acc_size),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq));

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 7'(a); reg_wdata = 32'(d);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int a, output longint v);
    reg_addr = 7'(a);
    #1;
    v = longint'(reg_rdata);
  endtask

  task automatic access(input int a, input bit w, input int c, input int s);
    @(negedge clk);
    acc_vld = 1'b1; acc_addr = AW'(a); acc_wr = w; acc_cli = 2'(c); acc_size = SW'(s);
    @(negedge clk);
    acc_vld = 1'b0;
  endtask

  function automatic bit model_hit(input int k, input int a, input bit w, input int c);
    if (a < lo[k] || a > hi[k]) return 0;
    if (((opm[k] >> (w ? 1 : 0)) & 1) == 0) return 0;
    return ((clm[k] >> c) & 1) == 1;
  endfunction

  task automatic clear_all();
    for (int k = 0; k < 4; k++) wr(16*k + 9, 0);
    wr(66, 15);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    longint v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int k = 0; k < 4; k++)
      for (int o = 0; o < 9; o++) begin
        rd(16*k + o, v); check("R1 reset reg", v, 0);
      end
    rd(64, v); check("R1 mask", v, 0);
    rd(67, v); check("R1 pending", v, 0);
    check("R1 irq", irq, 0);

    // configure and read back (R8)
    for (int k = 0; k < 4; k++) begin
      wr(16*k + 0, lo[k]); wr(16*k + 1, hi[k]);
      wr(16*k + 2, opm[k]); wr(16*k + 3, clm[k]);
    end
    wr(64, 15);
    for (int k = 0; k < 4; k++) begin
      rd(16*k + 0, v); check("R8 first readback", v, lo[k]);
      rd(16*k + 1, v); check("R8 last readback", v, hi[k]);
      rd(16*k + 2, v); check("R8 opmask readback", v, opm[k]);
      rd(16*k + 3, v); check("R8 climask readback", v, clm[k]);
    end
    rd(64, v); check("R8 mask readback", v, 15);
    rd(12, v); check("R8 unmapped slot offset", v, 0);
    rd(70, v); check("R8 unmapped global", v, 0);

    // sweep: R2 match rule (incl. single-address and reversed windows), R3 capture, R7
    for (int a = 0; a < 48; a++)
      for (int w = 0; w < 2; w++)
        for (int c = 0; c < NC; c++) begin
          int exp_vec;
          clear_all();
          access(a, bit'(w), c, (a + c) % 8);
          exp_vec = 0;
          for (int k = 0; k < 4; k++) if (model_hit(k, a, bit'(w), c)) exp_vec |= (1 << k);
          rd(65, v); check("R2 status vector", v, exp_vec);
          check("R7 irq", irq, exp_vec != 0);
          for (int k = 0; k < 4; k++) if (((exp_vec >> k) & 1) == 1) begin
            rd(16*k + 5, v); check("R3 cap addr", v, a);
            rd(16*k + 6, v); check("R3 cap op", v, w ? 2 : 1);
            rd(16*k + 7, v); check("R3 cap client idx", v, c);
            rd(16*k + 4, v); check("R3 cap client set", v, 1 << c);
            rd(16*k + 8, v); check("R3 cap size", v, (a + c) % 8);
          end
        end

    // R4 freeze on first hit
    clear_all();
    access(12, 0, 0, 1);
    access(18, 0, 1, 5);
    rd(5, v); check("R4 addr frozen", v, 12);
    rd(8, v); check("R4 size frozen", v, 1);
    rd(7, v); check("R4 client frozen", v, 0);

    // global ack alone clears pending but does not re-arm (R6, R5)
    wr(66, 1);
    rd(67, v); check("R6 global ack clears bit0", v & 1, 0);
    access(19, 0, 1, 2);
    rd(67, v); check("R6 re-pended", v & 1, 1);
    rd(5, v); check("R5 global ack no re-arm", v, 12);
    // per-slot ack re-arms, keeps pending
    wr(9, 0);
    rd(67, v); check("R5 slot ack keeps pending", v & 1, 1);
    access(20, 0, 0, 6);
    rd(5, v); check("R5 re-armed capture", v, 20);
    rd(8, v); check("R5 re-armed size", v, 6);

    // R6 hit wins over same-cycle clear
    clear_all();
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 7'd66; reg_wdata = 32'd2;
    acc_vld = 1'b1; acc_addr = AW'(15); acc_wr = 1'b1; acc_cli = 2'd2;
    @(negedge clk);
    reg_we = 1'b0; acc_vld = 1'b0;
    rd(67, v); check("R6 set wins", (v >> 1) & 1, 1);

    // R7 masking
    clear_all();
    wr(64, 0);
    access(15, 0, 3, 0);
    rd(65, v); check("R7 masked status zero", v, 0);
    check("R7 irq masked", irq, 0);
    rd(67, v); check("R7 raw pending", v, 2);
    wr(64, 2);
    check("R7 irq unmasked", irq, 1);
    wr(64, 15);

    // R9 idle strobe ignored
    clear_all();
    @(negedge clk);
    acc_vld = 1'b0; acc_addr = AW'(15); acc_wr = 1'b0; acc_cli = 2'd0;
    @(negedge clk);
    rd(67, v); check("R9 no pending when idle", v, 0);
    check("R9 irq low when idle", irq, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule